// File: doc/BRIEF.md
# First-Order Pulse-Density Modulator

This block turns an n-bit code into a one-bit stream whose density of high clocks is proportional to the code. Each enabled clock adds the code to an n-bit running sum; the carry out of that addition becomes the output bit for that clock. High clocks are therefore spread across the carrier period rather than grouped into one run. The effective carrier frequency depends on the code, and it is highest at midscale. An external RC low-pass filter on the output recovers an analog level.

The code comes from one of two sources, and a parameter picks which. One is an external input port. The other is a built-in sine sequencer that steps through a 100-point sine table, with midscale at 2^(n-1) and amplitude 2^(n-1)-1, and moves to the next sample after a fixed number of enabled clocks. With the defaults (5-bit code, five clocks per sample) a 500 kHz clock yields a new output bit every 2 µs, a 100 kHz sample rate and a 1 kHz sine after filtering.

Top module: `pdm_modulator`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the output is low and the running sum is zero. After reset with code 2^(n-1), the first output is 0 and the second is 1.
- R2: On every enabled clock, the code is added modulo 2^n to the running sum. The carry out of that addition appears on `pdm_out` after that edge and is held until the next edge. For example, code 12 with n=5 from reset gives 0,0,1,0,0,1.
- R3: With a constant code k, any 2^n consecutive enabled clocks contain exactly k high output clocks, whatever the starting sum.
- R4: Code 0 keeps the output low on every clock.
- R5: Code 2^n-1 from reset gives one low clock followed by 2^n-1 contiguous high clocks, then repeats.
- R6: Code 2^(n-1) from reset makes the output alternate 0,1,0,1 on successive clocks.
- R7: For codes up to 2^(n-1), held over two clocks, a high output clock is never followed directly by another high clock.
- R8: While `en` is low, the output is forced low and the running sum keeps its value. After `en` returns, the next addition starts from the held sum.
- R9: When `USE_TABLE`=1, the code comes from the sine sequencer. The sequencer starts at entry 0 (value 2^(n-1)) after reset and advances once every `SAMPLE_DIV` enabled clocks. Over one full table period from reset (100·`SAMPLE_DIV` enabled clocks) the output has exactly half that many high clocks, because the table sums to 100·2^(n-1). When `USE_TABLE`=0, `ext_code` is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable for the running sum and the sequencer |
| ext_code | input | DATA_W | Code used when USE_TABLE=0 |
| pdm_out | output | 1 | Registered pulse-density output |

## Verification
The checker's properties take it for granted that the code is steady between edges and free of X once reset is released. The burst and run properties also assume the code was held over the two clocks they span. The stimulus changes the code and `en` only just after a rising edge. It keeps reset asserted for several clocks before any run, and it changes codes only at window boundaries, so every property sees settled, known inputs.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    // Sine table entry i of len, for a code of w bits.
    // The second half mirrors the first, so the table sums to len*mid.
    function automatic longint sine_code(longint i, longint len, longint w);
        longint mid;
        longint amp;
        longint half;
        longint j;
        longint a;
        longint p;
        longint den;
        longint mag;
        mid  = longint'(1) << (w - 1);
        amp  = mid - 1;
        half = len / 2;
        j    = (i < half) ? i : i - half;
        a    = (3600 * j) / len;              // angle in tenths of a degree, 0..1799
        p    = a * (1800 - a);
        den  = 4050000 - p;
        mag  = (2 * amp * 4 * p + den) / (2 * den);
        return (i < half) ? mid + mag : mid - mag;
    endfunction

endpackage

// File: rtl/pdm_sine_src.sv
module pdm_sine_src #(
    parameter int W   = 5,
    parameter int LEN = 100,
    parameter int DIV = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] code
);
    localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN - 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [DIV_W-1:0] div;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [W-1:0] rom [LEN];

    for (genvar g = 0; g < LEN; g++) begin : g_rom
        assign rom[g] = W'(pdm_pkg::sine_code(g, LEN, W));
    end

    always_comb begin
        seq_d = seq_q;
        if (en) begin
            if (seq_q.div == DIV_LAST) begin
                seq_d.div = '0;
                seq_d.idx = (seq_q.idx == IDX_LAST) ? '0 : seq_q.idx + 1'b1;
            end else begin
                seq_d.div = seq_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign code = rom[seq_q.idx];
endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] code,
    output logic         bit_out
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         bit_o;
    } acc_t;

    acc_t st_d, st_q;
    logic [W:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.acc} + {1'b0, code};
        if (en) begin
            st_d.acc   = sum_d[W-1:0];
            st_d.bit_o = sum_d[W];
        end else begin
            st_d.bit_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bit_out = st_q.bit_o;
endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator #(
    parameter int DATA_W     = 5,
    parameter int TABLE_LEN  = 100,
    parameter int SAMPLE_DIV = 5,
    parameter bit USE_TABLE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] ext_code,
    output logic              pdm_out
);
    logic [DATA_W-1:0] tbl_code;
    logic [DATA_W-1:0] code_sel;

    pdm_sine_src #(.W(DATA_W), .LEN(TABLE_LEN), .DIV(SAMPLE_DIV)) src_i (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .code (tbl_code)
    );

    assign code_sel = USE_TABLE ? tbl_code : ext_code;

    pdm_accum #(.W(DATA_W)) acc_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .code    (code_sel),
        .bit_out (pdm_out)
    );
endmodule

// File: rtl/pdm_modulator_chk.sv
module pdm_modulator_chk #(
    parameter int W = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [W-1:0] code,
    input logic         pdm_out
);
    localparam logic [W-1:0] MID = W'(1 << (W - 1));
    localparam logic [W-1:0] MAX = '1;

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !pdm_out);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pdm_out);

    // R4
    zero_code_chk: assert property (@(posedge clk) disable iff (rst)
        (en && code == '0) |=> !pdm_out);

    // R7
    no_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (pdm_out && en && $past(en) && code <= MID && $past(code) <= MID)
        |=> !pdm_out);

    // R5
    max_run_chk: assert property (@(posedge clk) disable iff (rst)
        (!pdm_out && en && $past(en) && !$past(rst) && code == MAX && $past(code) == MAX)
        |=> pdm_out);
endmodule

bind pdm_modulator pdm_modulator_chk #(.W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .code    (code_sel),
    .pdm_out (pdm_out)
);

// File: tb/pdm_modulator_tb_top.sv
module pdm_modulator_tb_top;
    localparam int W   = 5;
    localparam int DIV = 5;
    localparam int LEN = 100;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         en_tbl = 1'b0;
    logic [W-1:0] code = '0;
    logic         out_ext;
    logic         out_tbl;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    pdm_modulator #(.DATA_W(W), .TABLE_LEN(LEN), .SAMPLE_DIV(DIV), .USE_TABLE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .en(en), .ext_code(code), .pdm_out(out_ext));

    pdm_modulator #(.DATA_W(W), .TABLE_LEN(LEN), .SAMPLE_DIV(DIV), .USE_TABLE(1'b1)) tbl_i (
        .clk(clk), .rst(rst), .en(en_tbl), .ext_code('0), .pdm_out(out_tbl));

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        code = 5'd31;
        repeat (6) step();
        rst = 1'b1;
        step();
        check(out_ext == 1'b0, "R1 out low in reset", out_ext, 0);
        rst = 1'b0;
        code = 5'd16;
        step();
        check(out_ext == 1'b0, "R1 first out after reset", out_ext, 0);
        step();
        check(out_ext == 1'b1, "R1 second out after reset", out_ext, 1);
    endtask

    task automatic t_add();
        int exp_seq [6] = '{0, 0, 1, 0, 0, 1};
        do_reset();
        code = 5'd12;
        for (int i = 0; i < 6; i++) begin
            step();
            check(out_ext == exp_seq[i][0], "R2 code 12 carry sequence", out_ext, exp_seq[i]);
        end
    endtask

    task automatic t_window();
        for (int k = 0; k < 32; k++) begin
            int ones = 0;
            code = W'(k);
            for (int c = 0; c < 32; c++) begin
                step();
                ones += int'(out_ext);
            end
            check(ones == k, "R3 highs per 32-clock window", ones, k);
        end
    endtask

    task automatic t_zero();
        int ones = 0;
        do_reset();
        code = '0;
        for (int c = 0; c < 64; c++) begin
            step();
            ones += int'(out_ext);
        end
        check(ones == 0, "R4 code 0 never high", ones, 0);
    endtask

    task automatic t_max();
        int bad = 0;
        do_reset();
        code = 5'd31;
        step();
        check(out_ext == 1'b0, "R5 first clock low", out_ext, 0);
        for (int c = 0; c < 31; c++) begin
            step();
            if (!out_ext) bad++;
        end
        check(bad == 0, "R5 31 contiguous highs", bad, 0);
        step();
        check(out_ext == 1'b0, "R5 single low repeats", out_ext, 0);
    endtask

    task automatic t_mid();
        int bad = 0;
        do_reset();
        code = 5'd16;
        for (int c = 1; c <= 16; c++) begin
            step();
            if (out_ext != c[0] ^ 1'b1) bad++;
        end
        check(bad == 0, "R6 midscale alternates", bad, 0);
    endtask

    task automatic t_no_burst();
        int runs = 0;
        for (int k = 1; k <= 16; k++) begin
            logic prev = 1'b0;
            code = W'(k);
            step();
            prev = out_ext;
            for (int c = 0; c < 64; c++) begin
                step();
                if (prev && out_ext) runs++;
                prev = out_ext;
            end
        end
        check(runs == 0, "R7 no back-to-back highs up to midscale", runs, 0);
    endtask

    task automatic t_disable();
        int ones = 0;
        do_reset();
        code = 5'd31;
        repeat (5) step();
        check(out_ext == 1'b1, "R8 high before disable", out_ext, 1);
        en = 1'b0;
        code = 5'd9;
        for (int c = 0; c < 6; c++) begin
            step();
            ones += int'(out_ext);
        end
        check(ones == 0, "R8 low while disabled", ones, 0);
        en = 1'b1;
        code = 5'd5;
        step();
        check(out_ext == 1'b1, "R8 sum held across disable", out_ext, 1);
        step();
        check(out_ext == 1'b0, "R8 sum wrapped to zero", out_ext, 0);
    endtask

    task automatic t_table();
        int exp_seq [5] = '{0, 1, 0, 1, 0};
        int ones = 0;
        en = 1'b0;
        rst = 1'b1;
        en_tbl = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        for (int c = 0; c < LEN * DIV; c++) begin
            step();
            if (c < 5)
                check(out_tbl == exp_seq[c][0], "R9 table entry 0 is midscale", out_tbl, exp_seq[c]);
            ones += int'(out_tbl);
        end
        check(ones == LEN * DIV / 2, "R9 highs over one sine period", ones, LEN * DIV / 2);
        en_tbl = 1'b0;
    endtask

    initial begin
        step();
        check(out_ext == 1'b0 && out_tbl == 1'b0, "R1 outputs low at reset",
              int'(out_ext) + int'(out_tbl), 0);
        t_reset();
        t_add();
        t_window();
        t_zero();
        t_max();
        t_mid();
        t_no_burst();
        t_disable();
        t_table();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule